// File: doc/BRIEF.md
# Programmable Baud Rate Generator

The block divides the system clock down to a serial bit clock. A 16-bit time constant, supplied as a low byte and a high byte, sets a down-counter. Each time the counter runs out, it reloads and toggles a square-wave output. The output therefore runs at the system clock frequency divided by twice the sum of the time constant and two. A single-cycle enable pulse marks every rising edge of that output. A clock-mode stage then divides those pulses by 1, 16, 32 or 64 to give the per-bit tick used by the serial transmitter and receiver.

The counter runs only when the countdown enable is set and the system clock is chosen as the counting source. Otherwise it parks at the reload value, with its output low and the mode divider cleared. A status output is high in the cycle in which the counter holds zero, the cycle just before the output toggles. A new time constant is picked up only at the next reload, so software can rewrite the two bytes while the generator runs without producing a short or garbled half period.

Top module: `brg_gen`

## Requirements
- R1: While running, each half period of `brgClk` lasts exactly TC+2 clock cycles. Rising-edge pulses on `brgClkEn` are spaced 2×(TC+2) cycles apart, and `brgClkEn` is high only while `brgClk` is high.
- R2: The time constant TC is the 16-bit value `{tcHigh, tcLow}`, with the high byte in bits 15:8. The full range 0 to 65535 is usable.
- R3: While `brgEnable` is 0, `brgClk`, `brgClkEn`, `bitTick` and `zeroCount` are all 0. After the enable is set, the first `brgClkEn` pulse is sampled in the cycle that follows the (TC+2)-th rising clock edge.
- R4: While `pclkSelect` is 0, the counter does not advance and the outputs stay as in R3. When `pclkSelect` returns to 1, a full first half period of TC+2 cycles follows.
- R5: A change of TC during a half period leaves that half period at the old length. The new value governs the half periods that follow.
- R6: `bitTick` marks every M-th `brgClkEn` pulse, where `clockMode` 00 gives M=1, 01 gives M=16, 10 gives M=32 and 11 gives M=64.
- R7: `zeroCount` is high for exactly one cycle per half period, in the cycle before `brgClk` toggles, and only while the generator runs.
- R8: During reset, all outputs are 0.
- R9: `bitTick` is never high without `brgClkEn`.
- R10: Stopping the generator clears the mode divider, so the first `bitTick` after a restart falls on the M-th pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the counting source |
| rstN | input | 1 | Asynchronous active-low reset |
| tcLow | input | 8 | Time constant bits 7:0 |
| tcHigh | input | 8 | Time constant bits 15:8 |
| brgEnable | input | 1 | Countdown enable |
| pclkSelect | input | 1 | 1 selects the system clock as counting source |
| clockMode | input | 2 | Bit-rate multiplier: 00 x1, 01 x16, 10 x32, 11 x64 |
| brgClk | output | 1 | Square-wave generator output |
| brgClkEn | output | 1 | One-cycle pulse on each rising edge of brgClk |
| bitTick | output | 1 | One-cycle pulse per bit period |
| zeroCount | output | 1 | Counter holds zero this cycle |

## Verification
The assertions assume that `brgEnable`, `pclkSelect` and `clockMode` are synchronous to `clk` and stable around the rising edge. The toggle and hold properties relate the run condition sampled at one edge to the output after that edge. The stimulus changes every input only on the falling clock edge. It raises the enable only after reset has been released, so the counter always starts from a reload value rather than from the reset contents.

// File: rtl/brg_pkg.sv
package brg_pkg;
  // Strobes from the control decoder to the counting datapath
  typedef struct packed {
    logic park;       // not running: preload and force output low
    logic reload;     // count exhausted: reload time constant
    logic toggle;     // flip the square-wave output
    logic countDown;  // decrement the counter
  } brgStrobes_t;
endpackage

// File: rtl/brg_ctrl.sv
module brg_ctrl
  import brg_pkg::*;
(
  input  logic        brgEnable,
  input  logic        pclkSelect,
  input  logic        cntZero,
  output brgStrobes_t strobes,
  output logic        zeroSeen
);
  logic run;

  always_comb begin
    run               = brgEnable & pclkSelect;
    strobes.park      = ~run;
    strobes.reload    = run & cntZero;
    strobes.toggle    = run & cntZero;
    strobes.countDown = run & ~cntZero;
    zeroSeen          = run & cntZero;
  end
endmodule

// File: rtl/brg_datapath.sv
module brg_datapath
  import brg_pkg::*;
#(
  parameter int TC_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [TC_W-1:0] tcValue,
  input  brgStrobes_t     strobes,
  output logic            cntZero,
  output logic            brgLevel,
  output logic            brgEdge
);
  // One extra bit so the reload value TC+1 never wraps
  localparam int CNT_W = TC_W + 1;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] reloadVal;

  // Counting TC+1 down to 0 gives TC+2 cycles per half period
  assign reloadVal = CNT_W'(tcValue) + CNT_W'(1);
  assign cntZero   = (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      brgLevel <= 1'b0;
      brgEdge  <= 1'b0;
    end else if (strobes.park) begin
      count    <= reloadVal;
      brgLevel <= 1'b0;
      brgEdge  <= 1'b0;
    end else begin
      if (strobes.reload) begin
        count <= reloadVal;
      end else if (strobes.countDown) begin
        count <= count - CNT_W'(1);
      end
      if (strobes.toggle) begin
        brgLevel <= ~brgLevel;
        brgEdge  <= ~brgLevel;
      end else begin
        brgEdge  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/brg_mode_div.sv
module brg_mode_div #(
  parameter int MODE_W     = 2,
  parameter int SHIFT_BASE = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              edgePulse,
  input  logic [MODE_W-1:0] clockMode,
  output logic              bitTick
);
  // Largest multiplier is 2^((2^MODE_W - 1) + SHIFT_BASE)
  localparam int DIV_W = (1 << MODE_W) - 1 + SHIFT_BASE;

  logic [DIV_W-1:0] divCount;
  logic [DIV_W-1:0] lastIdx;
  logic             atLast;

  always_comb begin
    if (clockMode == '0) begin
      lastIdx = '0;
    end else begin
      lastIdx = DIV_W'((1 << (int'(clockMode) + SHIFT_BASE)) - 1);
    end
  end

  // A mode change that leaves the count beyond the new limit wraps at once
  assign atLast  = (divCount >= lastIdx);
  assign bitTick = edgePulse & atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCount <= '0;
    end else if (clear) begin
      divCount <= '0;
    end else if (edgePulse) begin
      divCount <= atLast ? '0 : divCount + DIV_W'(1);
    end
  end
endmodule

// File: rtl/brg_gen.sv
module brg_gen
  import brg_pkg::*;
#(
  parameter int TC_W   = 16,
  parameter int MODE_W = 2,
  localparam int HALF_W = TC_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HALF_W-1:0] tcLow,
  input  logic [HALF_W-1:0] tcHigh,
  input  logic              brgEnable,
  input  logic              pclkSelect,
  input  logic [MODE_W-1:0] clockMode,
  output logic              brgClk,
  output logic              brgClkEn,
  output logic              bitTick,
  output logic              zeroCount
);
  brgStrobes_t     strobes;
  logic            cntZero;
  logic [TC_W-1:0] tcValue;

  assign tcValue = {tcHigh, tcLow};

  brg_ctrl u_ctrl (
    .brgEnable (brgEnable),
    .pclkSelect(pclkSelect),
    .cntZero   (cntZero),
    .strobes   (strobes),
    .zeroSeen  (zeroCount)
  );

  brg_datapath #(.TC_W(TC_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tcValue (tcValue),
    .strobes (strobes),
    .cntZero (cntZero),
    .brgLevel(brgClk),
    .brgEdge (brgClkEn)
  );

  brg_mode_div #(.MODE_W(MODE_W)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (strobes.park),
    .edgePulse(brgClkEn),
    .clockMode(clockMode),
    .bitTick  (bitTick)
  );
endmodule

// File: rtl/brg_gen_sva.sv
module brg_gen_sva (
  input logic clk,
  input logic rstN,
  input logic brgEnable,
  input logic pclkSelect,
  input logic brgClk,
  input logic brgClkEn,
  input logic bitTick,
  input logic zeroCount
);
  assert_park_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!brgEnable || !pclkSelect) |=> (!brgClk && !brgClkEn));

  assert_zero_needs_run_R7: assert property (@(posedge clk) disable iff (!rstN)
    zeroCount |-> (brgEnable && pclkSelect));

  assert_zero_toggles_R7: assert property (@(posedge clk) disable iff (!rstN)
    zeroCount |=> (brgClk != $past(brgClk)));

  assert_hold_level_R1: assert property (@(posedge clk) disable iff (!rstN)
    (brgEnable && pclkSelect && !zeroCount) |=> $stable(brgClk));

  assert_pulse_on_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    brgClkEn |-> brgClk);

  assert_tick_in_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> brgClkEn);
endmodule

bind brg_gen brg_gen_sva u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .brgEnable (brgEnable),
  .pclkSelect(pclkSelect),
  .brgClk    (brgClk),
  .brgClkEn  (brgClkEn),
  .bitTick   (bitTick),
  .zeroCount (zeroCount)
);

// File: tb/brg_gen_test.sv
module brg_gen_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic [7:0] tcLow = '0;
  logic [7:0] tcHigh = '0;
  logic       brgEnable = 1'b0;
  logic       pclkSelect = 1'b1;
  logic [1:0] clockMode = '0;
  logic       brgClk, brgClkEn, bitTick, zeroCount;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  brg_gen uut (
    .clk(clk), .rstN(rstN), .tcLow(tcLow), .tcHigh(tcHigh),
    .brgEnable(brgEnable), .pclkSelect(pclkSelect), .clockMode(clockMode),
    .brgClk(brgClk), .brgClkEn(brgClkEn), .bitTick(bitTick), .zeroCount(zeroCount)
  );

  // Vector: [31:24] tcHigh, [23:16] tcLow, [15:14] clockMode, [6:0] multiplier
  localparam int NVEC = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0000_0001,
    32'h0005_4010,
    32'h0102_8020,
    32'h0003_C040,
    32'h0200_0001,
    32'h00FF_4010
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Starts the generator (at a falling edge) and measures one full run
  task automatic measureRun(input int t, input int m);
    int cyc = 0, pulses = 0, firstLat = 0, gap = 0;
    int highCnt = 0, zeroCnt = 0, tickPulse = 0;
    bit prevZero = 0, prevZeroOk = 1, badTick = 0;
    brgEnable = 1'b1;
    while (!(pulses >= 2 && tickPulse != 0)) begin
      step();
      cyc++;
      if (bitTick && !brgClkEn) badTick = 1;
      if (brgClkEn) begin
        pulses++;
        if (!prevZero) prevZeroOk = 0;
        if (pulses == 1) firstLat = cyc;
        if (pulses == 2) gap = cyc - firstLat;
        if (bitTick && tickPulse == 0) tickPulse = pulses;
      end
      if (pulses == 1) begin
        if (brgClk) highCnt++;
        if (zeroCount) zeroCnt++;
      end
      prevZero = zeroCount;
    end
    brgEnable = 1'b0;
    check(firstLat == t + 2, "R3/R2 first pulse latency", firstLat, t + 2);
    check(gap == 2 * (t + 2), "R1 pulse spacing", gap, 2 * (t + 2));
    check(highCnt == t + 2, "R1 high half length", highCnt, t + 2);
    check(zeroCnt == 2, "R7 zeroCount cycles per period", zeroCnt, 2);
    check(prevZeroOk, "R7 zeroCount precedes toggle", prevZeroOk, 1);
    check(tickPulse == m, "R6 bitTick pulse index", tickPulse, m);
    check(!badTick, "R9 bitTick outside brgClkEn", badTick, 0);
    step();
    step();
  endtask

  // Counts samples with no activity while the generator is held off
  task automatic quietFor(input int n, input string req);
    int active = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (brgClk || brgClkEn || bitTick || zeroCount) active++;
    end
    check(active == 0, req, active, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    finishRun();
  end

  initial begin
    int cyc;
    int pulses;
    @(negedge clk);
    rstN = 1'b0;
    step();
    // R8: reset state
    check(!brgClk && !brgClkEn, "R8 reset brgClk/brgClkEn", brgClk + brgClkEn, 0);
    check(!bitTick && !zeroCount, "R8 reset bitTick/zeroCount", bitTick + zeroCount, 0);
    step();
    rstN = 1'b1;
    step();

    // Table-driven runs: R1, R2, R3, R6, R7, R9
    for (int i = 0; i < NVEC; i++) begin
      tcHigh    = VEC[i][31:24];
      tcLow     = VEC[i][23:16];
      clockMode = VEC[i][15:14];
      step();
      measureRun(int'({VEC[i][31:24], VEC[i][23:16]}), int'(VEC[i][6:0]));
    end

    // R3: disabled generator stays quiet
    tcHigh = 8'h00; tcLow = 8'h02; clockMode = 2'b00;
    quietFor(40, "R3 quiet while disabled");

    // R3: stopping mid-run forces the output low on the next sample
    brgEnable = 1'b1;
    cyc = 0;
    do begin step(); cyc++; end while (!brgClk && cyc < 100);
    brgEnable = 1'b0;
    step();
    check(!brgClk && !brgClkEn, "R3 output low after stop", brgClk, 0);

    // R4: source deselected holds the counter
    pclkSelect = 1'b0;
    brgEnable  = 1'b1;
    tcLow      = 8'h07;
    quietFor(40, "R4 quiet without source");
    pclkSelect = 1'b1;
    cyc = 0;
    do begin step(); cyc++; end while (!brgClkEn && cyc < 100);
    check(cyc == 9, "R4 full half period after source returns", cyc, 9);
    brgEnable = 1'b0;
    step();

    // R5: time constant change mid half period
    tcLow = 8'd10;
    brgEnable = 1'b1;
    cyc = 0;
    do begin step(); cyc++; end while (!brgClkEn && cyc < 100);
    cyc = 0;
    step(); cyc++;
    step(); cyc++;
    tcLow = 8'd2;
    do begin step(); cyc++; end while (brgClk && cyc < 100);
    check(cyc == 12, "R5 current half keeps old TC", cyc, 12);
    cyc = 0;
    do begin step(); cyc++; end while (!brgClkEn && cyc < 100);
    check(cyc == 4, "R5 next half uses new TC", cyc, 4);
    brgEnable = 1'b0;
    step();

    // R10: divider cleared by stop, x16 mode
    tcLow = 8'd0;
    clockMode = 2'b01;
    brgEnable = 1'b1;
    pulses = 0;
    while (pulses < 5) begin step(); if (brgClkEn) pulses++; end
    brgEnable = 1'b0;
    step();
    step();
    brgEnable = 1'b1;
    pulses = 0;
    cyc = 0;
    do begin
      step();
      cyc++;
      if (brgClkEn) pulses++;
    end while (!bitTick && cyc < 2000);
    check(pulses == 16, "R10 first tick after restart", pulses, 16);
    brgEnable = 1'b0;
    step();

    // R2: largest time constant, first half period only
    tcHigh = 8'hFF;
    tcLow  = 8'hFF;
    clockMode = 2'b00;
    step();
    brgEnable = 1'b1;
    cyc = 0;
    do begin step(); cyc++; end while (!brgClkEn && cyc < 70000);
    check(cyc == 65537, "R2 full-range time constant", cyc, 65537);
    brgEnable = 1'b0;
    step();

    finishRun();
  end
endmodule